// File: doc/BRIEF.md
# Four-Mode Serial Port with Divisor-Based Bit Clock

This block is a full-duplex serial port driven through a small byte-wide register port. Software writes a byte to the data register to start a transfer, reads received bytes from the same address, and watches a status register whose flags also drive the transmit and receive interrupt lines. The port supports four modes: a synchronous shift mode for driving external shift registers, an 8-bit asynchronous mode, and two 9-bit asynchronous modes. In one of the 9-bit modes the receiver accepts only frames whose ninth bit is set. This lets a group of nodes on a shared line ignore data frames until a frame addresses them.

The bit clock comes from a private divisor counter that is independent of any other timer. Its 16-bit setting is loaded through a single byte address with two consecutive writes. The top bit of that setting chooses whether the counter advances on every system clock or on rising edges of an external clock pin. The asynchronous modes oversample by eight ticks per bit. The synchronous mode produces one shift-clock half period per tick.

Top module: `sio_port`

## Requirements
- R1: After reset, txd_o and rxd_o are 1, rxd_oe_o is 0, both interrupt outputs are 0, and the status and control registers (addresses 2 and 1) read as 0.
- R2: Address 3 takes the divisor in two writes, low byte first and then high byte. Bits 14:0 form a reload value N, and one tick occurs every N+1 counter steps. An asynchronous bit lasts 8 ticks.
- R3: When divisor bit 15 is 1, the counter steps on every clk cycle. When it is 0, the counter steps once per rising edge of ext_clk_i.
- R4: In mode 1 (control bits 1:0 = 1), a write to the data register (address 0) sends one low start bit, 8 data bits LSB first and one high stop bit on txd_o. txd_o is high whenever the transmitter is idle.
- R5: In modes 2 and 3, a ninth bit is sent after the 8 data bits. Its value is taken from control bit 3.
- R6: With control bit 2 (receive enable) set in mode 1, a frame arriving on rxd_i is stored in the data register and sets the receive-done flag.
- R7: The receiver checks the start bit halfway through (4 ticks after detecting the low level). If the line is high at that point, it discards the attempt and leaves the flags and the buffer unchanged.
- R8: In mode 2, a received frame whose ninth bit is 0 leaves the buffer and the flag untouched, and a frame whose ninth bit is 1 is accepted. In mode 3 every frame is accepted. Status bit 2 holds the ninth bit of the last accepted frame.
- R9: In mode 0 with receive enable clear, a data write makes txd_o give 8 low pulses as a shift clock. Each data bit (LSB first) appears on rxd_o when the clock falls and is valid at the rising edge. rxd_oe_o is 1 during the transfer.
- R10: In mode 0 with receive enable set, a data write starts 8 shift clocks. rxd_i is sampled at each rising edge (LSB first), rxd_oe_o stays 0, and the assembled byte is stored in the buffer with the receive-done flag set.
- R11: Status bit 0 is receive-done, bit 1 is transmit-done and bit 3 is transmitter busy. A status read clears bits 0 and 1. rx_irq_o and tx_irq_o equal bits 0 and 1.
- R12: A data-register write while the transmitter is busy is ignored.
- R13: With receive enable clear, the asynchronous receiver ignores rxd_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register address: 0 data, 1 control, 2 status, 3 divisor |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (status read clears flags) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed register |
| ext_clk_i | input | 1 | Alternative counter clock, sampled on clk |
| rxd_i | input | 1 | Receive line, or data input in synchronous mode |
| txd_o | output | 1 | Transmit line, or shift clock in synchronous mode |
| rxd_o | output | 1 | Synchronous-mode data output |
| rxd_oe_o | output | 1 | Output enable for rxd_o |
| tx_irq_o | output | 1 | Transmit-done interrupt |
| rx_irq_o | output | 1 | Receive-done interrupt |

## Verification
A wrong divisor or a wrong clock-source choice changes the spacing of txd_o edges within the first two data bits of a frame. The bench therefore measures edge-to-edge distances rather than sampling at fixed cycles. A slipped shift pointer or bit counter appears at the end of a single frame as a wrong byte, a missing stop bit or a wrong shift-clock count. A flag that is set or cleared at the wrong time shows at the interrupt pins and on the next status read. For that reason every frame is followed by a status read and an interrupt-pin check, and the rejection and glitch cases are followed by a frame that must be accepted.

// File: rtl/sio_pkg.sv
package sio_pkg;
    typedef enum logic [1:0] {
        SIO_SYNC        = 2'd0,
        SIO_ASYNC8      = 2'd1,
        SIO_ASYNC9_ADDR = 2'd2,
        SIO_ASYNC9      = 2'd3
    } sio_mode_e;

    localparam logic [1:0] REG_DATA = 2'd0;
    localparam logic [1:0] REG_CTRL = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;
    localparam logic [1:0] REG_BAUD = 2'd3;
endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{INIT}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sio_baudgen.sv
module sio_baudgen #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             ext_clk_i,
    output logic             tick_o
);
    localparam int CNT_W = DIV_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ext_prev;
    } bg_state_t;

    bg_state_t st_d, st_q;
    logic ext_s;
    logic step;

    sio_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ext_clk_i), .q_o(ext_s)
    );

    always_comb begin
        st_d          = st_q;
        st_d.ext_prev = ext_s;
        step          = divisor_i[DIV_W-1] ? 1'b1 : (ext_s & ~st_q.ext_prev);
        tick_o        = 1'b0;
        if (step) begin
            if (st_q.cnt == '0) begin
                tick_o   = 1'b1;
                st_d.cnt = divisor_i[CNT_W-1:0];
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int OSR    = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [1:0]        mode_i,
    input  logic              rx_en_i,
    input  logic              ninth_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              rxd_i,
    output logic              txd_o,
    output logic              rxd_o,
    output logic              rxd_oe_o,
    output logic              busy_o,
    output logic              tx_done_o,
    output logic              sync_rx_done_o,
    output logic [DATA_W-1:0] shift_data_o
);
    localparam int SUB_W = $clog2(OSR);
    localparam int FR_W  = DATA_W + 2;
    localparam int CNT_W = $clog2(FR_W + 1);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(OSR - 1);

    typedef enum logic [1:0] {T_IDLE, T_ASYNC, T_SYNC} tx_phase_e;

    typedef struct packed {
        tx_phase_e        phase;
        logic [FR_W-1:0]  shreg;
        logic [CNT_W-1:0] left;
        logic [SUB_W-1:0] sub;
        logic             txd;
        logic             rxd;
        logic             oe;
        logic             rx_dir;
        logic             done_tx;
        logic             done_rx;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.done_tx = 1'b0;
        s_d.done_rx = 1'b0;
        case (s_q.phase)
            T_IDLE: begin
                if (start_i) begin
                    s_d.sub = '0;
                    if (mode_i == SIO_SYNC) begin
                        s_d.phase  = T_SYNC;
                        s_d.shreg  = {2'b11, data_i};
                        s_d.left   = CNT_W'(DATA_W);
                        s_d.rx_dir = rx_en_i;
                        s_d.oe     = ~rx_en_i;
                        s_d.txd    = 1'b1;
                    end else begin
                        s_d.phase = T_ASYNC;
                        s_d.txd   = 1'b0;
                        if (mode_i == SIO_ASYNC8) begin
                            s_d.shreg = {2'b11, data_i};
                            s_d.left  = CNT_W'(DATA_W + 1);
                        end else begin
                            s_d.shreg = {1'b1, ninth_i, data_i};
                            s_d.left  = CNT_W'(DATA_W + 2);
                        end
                    end
                end
            end
            T_ASYNC: begin
                if (tick_i) begin
                    s_d.sub = s_q.sub + 1'b1;
                    if (s_q.sub == LAST_SUB) begin
                        if (s_q.left == '0) begin
                            s_d.phase   = T_IDLE;
                            s_d.txd     = 1'b1;
                            s_d.done_tx = 1'b1;
                        end else begin
                            s_d.txd   = s_q.shreg[0];
                            s_d.shreg = {1'b1, s_q.shreg[FR_W-1:1]};
                            s_d.left  = s_q.left - 1'b1;
                        end
                    end
                end
            end
            T_SYNC: begin
                if (tick_i) begin
                    if (s_q.txd) begin
                        s_d.txd = 1'b0;
                        if (!s_q.rx_dir) s_d.rxd = s_q.shreg[0];
                    end else begin
                        s_d.txd   = 1'b1;
                        s_d.shreg = {s_q.shreg[FR_W-1:DATA_W], rxd_i, s_q.shreg[DATA_W-1:1]};
                        s_d.left  = s_q.left - 1'b1;
                        if (s_q.left == CNT_W'(1)) begin
                            s_d.phase   = T_IDLE;
                            s_d.oe      = 1'b0;
                            s_d.done_tx = ~s_q.rx_dir;
                            s_d.done_rx = s_q.rx_dir;
                        end
                    end
                end
            end
            default: s_d.phase = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= T_IDLE;
            s_q.txd   <= 1'b1;
            s_q.rxd   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd_o          = s_q.txd;
    assign rxd_o          = s_q.rxd;
    assign rxd_oe_o       = s_q.oe;
    assign busy_o         = (s_q.phase != T_IDLE);
    assign tx_done_o      = s_q.done_tx;
    assign sync_rx_done_o = s_q.done_rx;
    assign shift_data_o   = s_q.shreg[DATA_W-1:0];
endmodule

// File: rtl/sio_rx.sv
module sio_rx #(
    parameter int OSR    = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              nine_i,
    input  logic              rxd_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o
);
    localparam int SUB_W = $clog2(OSR);
    localparam int CNT_W = $clog2(DATA_W + 2);
    localparam logic [SUB_W-1:0] LAST_SUB = SUB_W'(OSR - 1);
    localparam logic [SUB_W-1:0] MID_SUB  = SUB_W'(OSR / 2 - 1);

    typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_phase_e;

    typedef struct packed {
        rx_phase_e        phase;
        logic [SUB_W-1:0] sub;
        logic [CNT_W-1:0] cnt;
        logic [DATA_W:0]  shreg;
        logic             done;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = nine_i ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!en_i) begin
            s_d.phase = R_IDLE;
        end else begin
            case (s_q.phase)
                R_IDLE: begin
                    if (tick_i && !rxd_i) begin
                        s_d.phase = R_START;
                        s_d.sub   = '0;
                    end
                end
                R_START: begin
                    if (tick_i) begin
                        s_d.sub = s_q.sub + 1'b1;
                        if (s_q.sub == MID_SUB) begin
                            if (rxd_i) begin
                                s_d.phase = R_IDLE;
                            end else begin
                                s_d.phase = R_DATA;
                                s_d.sub   = '0;
                                s_d.cnt   = '0;
                            end
                        end
                    end
                end
                R_DATA: begin
                    if (tick_i) begin
                        s_d.sub = s_q.sub + 1'b1;
                        if (s_q.sub == LAST_SUB) begin
                            s_d.shreg = {rxd_i, s_q.shreg[DATA_W:1]};
                            s_d.cnt   = s_q.cnt + 1'b1;
                            if (s_q.cnt == last_cnt) s_d.phase = R_STOP;
                        end
                    end
                end
                R_STOP: begin
                    if (tick_i) begin
                        s_d.sub = s_q.sub + 1'b1;
                        if (s_q.sub == LAST_SUB) begin
                            s_d.done  = 1'b1;
                            s_d.phase = R_IDLE;
                        end
                    end
                end
                default: s_d.phase = R_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= R_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign done_o = s_q.done;
    assign data_o = nine_i ? s_q.shreg[DATA_W-1:0] : s_q.shreg[DATA_W:1];
    assign bit9_o = nine_i & s_q.shreg[DATA_W];
endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int OSR         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] reg_addr_i,
    input  logic       reg_wr_i,
    input  logic       reg_rd_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    input  logic       ext_clk_i,
    input  logic       rxd_i,
    output logic       txd_o,
    output logic       rxd_o,
    output logic       rxd_oe_o,
    output logic       tx_irq_o,
    output logic       rx_irq_o
);
    localparam int BYTE_W = 8;
    localparam int HI_W   = DIV_W - BYTE_W;

    typedef struct packed {
        logic [1:0]        mode;
        logic              rx_en;
        logic              tb8;
        logic [DIV_W-1:0]  baud;
        logic              baud_hi;
        logic [BYTE_W-1:0] rx_buf;
        logic              rx_flag;
        logic              tx_flag;
        logic              rb8;
    } port_state_t;

    port_state_t r_d, r_q;

    logic              rxd_s;
    logic              tick;
    logic              tx_busy, tx_done, sync_rx_done;
    logic [BYTE_W-1:0] sync_rx_data;
    logic              arx_done, arx_bit9;
    logic [BYTE_W-1:0] arx_data;
    logic              arx_accept, rx_drop, rx_set;
    logic              stat_rd, baud_wr, tx_start;
    logic              baud_ptr;
    logic [BYTE_W-1:0] rx_buf;

    sio_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rxd_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rxd_i), .q_o(rxd_s)
    );

    sio_baudgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor_i(r_q.baud),
        .ext_clk_i(ext_clk_i), .tick_o(tick)
    );

    sio_tx #(.OSR(OSR), .DATA_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_i(r_q.mode),
        .rx_en_i(r_q.rx_en), .ninth_i(r_q.tb8), .start_i(tx_start),
        .data_i(reg_wdata_i), .rxd_i(rxd_s), .txd_o(txd_o), .rxd_o(rxd_o),
        .rxd_oe_o(rxd_oe_o), .busy_o(tx_busy), .tx_done_o(tx_done),
        .sync_rx_done_o(sync_rx_done), .shift_data_o(sync_rx_data)
    );

    sio_rx #(.OSR(OSR), .DATA_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .en_i(r_q.rx_en && (r_q.mode != SIO_SYNC)), .nine_i(r_q.mode[1]),
        .rxd_i(rxd_s), .done_o(arx_done), .data_o(arx_data), .bit9_o(arx_bit9)
    );

    always_comb begin
        stat_rd    = reg_rd_i && (reg_addr_i == REG_STAT);
        baud_wr    = reg_wr_i && (reg_addr_i == REG_BAUD);
        tx_start   = reg_wr_i && (reg_addr_i == REG_DATA) && !tx_busy;
        arx_accept = arx_done && ((r_q.mode != SIO_ASYNC9_ADDR) || arx_bit9);
        rx_drop    = arx_done && !arx_accept;
        rx_set     = arx_accept || sync_rx_done;

        r_d = r_q;
        if (reg_wr_i && (reg_addr_i == REG_CTRL)) begin
            r_d.mode  = reg_wdata_i[1:0];
            r_d.rx_en = reg_wdata_i[2];
            r_d.tb8   = reg_wdata_i[3];
        end
        if (baud_wr) begin
            if (r_q.baud_hi) r_d.baud[DIV_W-1:BYTE_W] = reg_wdata_i[HI_W-1:0];
            else             r_d.baud[BYTE_W-1:0]     = reg_wdata_i;
            r_d.baud_hi = ~r_q.baud_hi;
        end
        if (stat_rd) begin
            r_d.rx_flag = 1'b0;
            r_d.tx_flag = 1'b0;
        end
        if (tx_done) r_d.tx_flag = 1'b1;
        if (sync_rx_done) begin
            r_d.rx_buf  = sync_rx_data;
            r_d.rb8     = 1'b0;
            r_d.rx_flag = 1'b1;
        end
        if (arx_accept) begin
            r_d.rx_buf  = arx_data;
            r_d.rb8     = arx_bit9;
            r_d.rx_flag = 1'b1;
        end

        case (reg_addr_i)
            REG_DATA: reg_rdata_o = r_q.rx_buf;
            REG_CTRL: reg_rdata_o = {4'b0, r_q.tb8, r_q.rx_en, r_q.mode};
            REG_STAT: reg_rdata_o = {4'b0, tx_busy, r_q.rb8, r_q.tx_flag, r_q.rx_flag};
            default:  reg_rdata_o = r_q.baud[BYTE_W-1:0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_irq_o = r_q.tx_flag;
    assign rx_irq_o = r_q.rx_flag;
    assign baud_ptr = r_q.baud_hi;
    assign rx_buf   = r_q.rx_buf;
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              txd_i,
    input logic              busy_i,
    input logic              oe_i,
    input logic              tx_done_i,
    input logic              rx_set_i,
    input logic              rx_drop_i,
    input logic              stat_rd_i,
    input logic              tx_irq_i,
    input logic              rx_irq_i,
    input logic              baud_wr_i,
    input logic              baud_ptr_i,
    input logic [DATA_W-1:0] rx_buf_i
);
    p_idle_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> txd_i);

    p_oe_in_transfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_i |-> busy_i);

    p_tx_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> tx_irq_i);

    p_rx_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set_i |=> rx_irq_i);

    p_tx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !tx_done_i) |=> !tx_irq_i);

    p_rx_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !rx_set_i) |=> !rx_irq_i);

    p_byte_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        baud_wr_i |=> (baud_ptr_i != $past(baud_ptr_i)));

    p_drop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop_i |=> $stable(rx_buf_i));
endmodule

bind sio_port sio_port_chk #(.DATA_W(8)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd_i(txd_o), .busy_i(tx_busy), .oe_i(rxd_oe_o),
    .tx_done_i(tx_done), .rx_set_i(rx_set), .rx_drop_i(rx_drop),
    .stat_rd_i(stat_rd), .tx_irq_i(tx_irq_o), .rx_irq_i(rx_irq_o),
    .baud_wr_i(baud_wr), .baud_ptr_i(baud_ptr), .rx_buf_i(rx_buf)
);

// File: tb/sio_port_test.sv
module sio_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_clk = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, rxd_out, rxd_oe, tx_irq, rx_irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sio_port uut (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_i(reg_wr),
        .reg_rd_i(reg_rd), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ext_clk_i(ext_clk), .rxd_i(rxd), .txd_o(txd), .rxd_o(rxd_out),
        .rxd_oe_o(rxd_oe), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq)
    );

    initial forever begin
        repeat (4) @(negedge clk);
        ext_clk = ~ext_clk;
    end

    initial begin
        repeat (200000) @(negedge clk);
        failures++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; reg_rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic set_div(input logic [7:0] hi, input logic [7:0] lo);
        wr(2'd3, lo);
        wr(2'd3, hi);
    endtask

    task automatic wait_tx();
        logic [7:0] st;
        while (!tx_irq) @(negedge clk);
        rd(2'd2, st);
    endtask

    // decode an async frame already started on txd; bit length 8*p cycles
    task automatic get_frame(input int p, input int nb, output logic [8:0] bits,
                             output logic st, output logic sp);
        int b;
        b = 8 * p;
        bits = '0;
        while (txd) @(negedge clk);
        cycles(b / 2);
        st = txd;
        for (int k = 0; k < nb; k++) begin
            cycles(b);
            bits[k] = txd;
        end
        cycles(b);
        sp = txd;
    endtask

    task automatic send_frame(input int p, input int nb, input logic [8:0] v);
        int b;
        b = 8 * p;
        rxd = 1'b0;
        cycles(b);
        for (int k = 0; k < nb; k++) begin
            rxd = v[k];
            cycles(b);
        end
        rxd = 1'b1;
        cycles(b);
    endtask

    // distance between the falling edges of data bits 1 and 3 of 0x55
    task automatic measure(output int n);
        wr(2'd0, 8'h55);
        while (txd) @(negedge clk);
        while (!txd) @(negedge clk);
        while (txd) @(negedge clk);
        n = 0;
        while (!txd) begin @(negedge clk); n++; end
        while (txd) begin @(negedge clk); n++; end
        wait_tx();
    endtask

    initial begin
        logic [7:0] v;
        logic [8:0] bits;
        logic st, sp;
        int n;

        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // R1 reset state
        chk("R1 txd", txd, 1);
        chk("R1 rxd_o", rxd_out, 1);
        chk("R1 oe", rxd_oe, 0);
        chk("R1 irqs", {tx_irq, rx_irq}, 0);
        rd(2'd2, v); chk("R1 status", v, 0);
        rd(2'd1, v); chk("R1 ctrl", v, 0);

        // R2 divisor from two byte writes, main clock: N=5 -> 16*6
        wr(2'd1, 8'h01);
        set_div(8'h80, 8'h05);
        rd(2'd3, v); chk("R2 low byte readback", v, 8'h05);
        measure(n); chk("R2 two-bit span", n, 16 * 6);
        // R3 external clock source: N=2, edge every 8 clocks
        set_div(8'h00, 8'h02);
        measure(n); chk("R3 ext two-bit span", n, 16 * 3 * 8);

        // R4 mode 1 transmit sweep, P=2
        set_div(8'h80, 8'h01);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            d = 8'((i * 37 + 5) & 255);
            wr(2'd0, d);
            get_frame(2, 8, bits, st, sp);
            chk("R4 start bit", st, 0);
            chk("R4 data", bits[7:0], d);
            chk("R4 stop bit", sp, 1);
            while (!tx_irq) @(negedge clk);
            chk("R11 tx irq", tx_irq, 1);
            rd(2'd2, v); chk("R11 tx flag", v & 8'h0B, 8'h02);
            chk("R11 tx irq cleared", tx_irq, 0);
        end

        // R12 write while busy is ignored
        wr(2'd0, 8'hA5);
        wr(2'd0, 8'h3C);
        get_frame(2, 8, bits, st, sp);
        chk("R12 first frame kept", bits[7:0], 8'hA5);
        wait_tx();
        n = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!txd) n++;
        end
        chk("R12 no second frame", n, 0);
        rd(2'd2, v); chk("R12 idle status", v & 8'h0A, 0);

        // R5 ninth bit from control bit 3
        wr(2'd1, 8'h0B);
        wr(2'd0, 8'h5A);
        get_frame(2, 9, bits, st, sp);
        chk("R5 mode3 nine bits", bits, 9'h15A);
        chk("R5 stop", sp, 1);
        wait_tx();
        wr(2'd1, 8'h02);
        wr(2'd0, 8'hC3);
        get_frame(2, 9, bits, st, sp);
        chk("R5 mode2 nine bits", bits, 9'h0C3);
        wait_tx();

        // R6 mode 1 receive, all byte values
        wr(2'd1, 8'h05);
        for (int d = 0; d < 256; d++) begin
            send_frame(2, 8, 9'(d));
            cycles(2);
            chk("R6 rx irq", rx_irq, 1);
            rd(2'd2, v); chk("R6 rx flag", v & 8'h01, 1);
            rd(2'd0, v); chk("R6 rx data", v, d);
        end

        // R7 short low pulses are discarded, then a real frame is taken
        for (int w = 1; w <= 4; w++) begin
            rxd = 1'b0;
            cycles(w);
            rxd = 1'b1;
            cycles(100);
            chk("R7 glitch dropped", rx_irq, 0);
        end
        rd(2'd0, v); chk("R7 buffer unchanged", v, 8'hFF);
        send_frame(2, 8, 9'h03A);
        cycles(2);
        rd(2'd0, v); chk("R7 recovery frame", v, 8'h3A);
        rd(2'd2, v);

        // R13 receiver disabled
        wr(2'd1, 8'h01);
        send_frame(2, 8, 9'h0E7);
        cycles(4);
        chk("R13 no rx irq", rx_irq, 0);
        rd(2'd0, v); chk("R13 buffer unchanged", v, 8'h3A);

        // R8 address-filtered 9-bit mode and plain 9-bit mode
        wr(2'd1, 8'h06);
        send_frame(2, 9, 9'h111);
        cycles(2);
        rd(2'd2, v); chk("R8 mode2 ninth=1 accepted", v & 8'h05, 8'h05);
        rd(2'd0, v); chk("R8 mode2 data", v, 8'h11);
        send_frame(2, 9, 9'h022);
        cycles(2);
        chk("R8 mode2 ninth=0 no irq", rx_irq, 0);
        rd(2'd0, v); chk("R8 mode2 buffer kept", v, 8'h11);
        wr(2'd1, 8'h07);
        send_frame(2, 9, 9'h033);
        cycles(2);
        rd(2'd2, v); chk("R8 mode3 accepted ninth 0", v & 8'h05, 8'h01);
        rd(2'd0, v); chk("R8 mode3 data", v, 8'h33);

        // R9 synchronous transmit, P=4
        set_div(8'h80, 8'h03);
        wr(2'd1, 8'h00);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] d, got;
            d = (i == 0) ? 8'h96 : (i == 1) ? 8'h01 : (i == 2) ? 8'hFE : 8'h6D;
            got = '0;
            wr(2'd0, d);
            for (int k = 0; k < 8; k++) begin
                while (txd) @(negedge clk);
                if (k == 0) chk("R9 oe during shift", rxd_oe, 1);
                while (!txd) @(negedge clk);
                got[k] = rxd_out;
            end
            chk("R9 shifted data", got, d);
            cycles(2);
            chk("R9 done irq", tx_irq, 1);
            chk("R9 oe released", rxd_oe, 0);
            n = 0;
            for (int c = 0; c < 12; c++) begin
                @(negedge clk);
                if (!txd) n++;
            end
            chk("R9 exactly eight clocks", n, 0);
            rd(2'd2, v);
        end

        // R10 synchronous receive
        wr(2'd1, 8'h04);
        for (int i = 0; i < 3; i++) begin
            logic [7:0] d;
            d = (i == 0) ? 8'h5C : (i == 1) ? 8'hA3 : 8'h80;
            wr(2'd0, 8'h00);
            for (int k = 0; k < 8; k++) begin
                while (txd) @(negedge clk);
                chk("R10 oe stays low", rxd_oe, 0);
                rxd = d[k];
                while (!txd) @(negedge clk);
            end
            rxd = 1'b1;
            cycles(2);
            chk("R10 rx irq", rx_irq, 1);
            rd(2'd2, v); chk("R10 flags", v & 8'h03, 8'h01);
            rd(2'd0, v); chk("R10 data", v, d);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule